// File: doc/BRIEF.md
# Symbol-to-Byte Elastic Buffer with Justification Decision

This block sits between a line-symbol receiver and a byte-oriented frame mapper. A 5-bit symbol arrives on every edge of the symbol clock, with no gaps. The mapper, running on its own byte clock, pulls 8-bit bytes one at a time by raising a request for one byte-clock cycle. It stops pulling during the overhead columns of its outgoing frame. The buffer absorbs that irregular demand. Its storage is three groups of 40 bits each. Eight symbols fill a group exactly, and five bytes drain it.

Write progress is sent to the byte domain as a count of completed groups. Read progress is sent back to the symbol domain as a count of drained groups. Both counts are gray-coded and pass through two-flop synchronizers. In the byte domain the block computes its fill level from the difference between the two counts. A hysteresis comparator turns that fill into a justification decision for the mapper. The decision tells the mapper whether the next stuff opportunity carries payload or is a dummy bit. A symbol arriving with no free space, and a byte request with nothing to read, are each recorded in a sticky flag.

Top module: `sym2byte_elastic`

## Requirements
- R1: After both resets the byte output is 0, `justify` is 1, and both sticky flags are 0.
- R2: The byte stream is the symbol stream taken bit by bit. Symbol bit 0 goes first. The first bit taken into a byte becomes byte bit 0. With no overflow, every byte read equals the next eight bits of that stream.
- R3: A symbol that arrives while three written groups are still undrained, as seen by the write side, is discarded. The discard sets `ovf_flag`, which stays 1 until the symbol-side reset.
- R4: A byte request with no complete byte available leaves `byte_out` unchanged and advances nothing. It sets `udf_flag`, which stays 1 until the byte-side reset.
- R5: Bytes become readable only in whole groups. Symbols of a partly written group of eight cannot be read.
- R6: Fill is 40 bits times the number of completed groups seen by the reader, minus 8 bits per byte read from them. `justify` goes to 0 (the stuff bit carries data) one byte clock after the fill exceeds 64 bits.
- R7: `justify` returns to 1 one byte clock after the fill drops to 56 bits or less. At a fill of 57 to 64 bits it holds its previous value.
- R8: Storage and pointers wrap cyclically. Data stays correct over many wraps, and each gray pointer changes at most one bit per clock of its own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sym_clk | input | 1 | Symbol clock; one symbol written per edge |
| sym_rst_n | input | 1 | Synchronous active-low reset, symbol domain |
| sym_in | input | 5 | Incoming line symbol |
| byte_clk | input | 1 | Byte clock of the mapper |
| byte_rst_n | input | 1 | Synchronous active-low reset, byte domain |
| byte_next | input | 1 | Request for one byte in this cycle |
| byte_out | output | 8 | Last byte handed out, updated the edge after an accepted request |
| justify | output | 1 | 1: stuff bit is a dummy; 0: stuff bit carries data |
| ovf_flag | output | 1 | Sticky: a symbol was discarded for lack of space |
| udf_flag | output | 1 | Sticky: a byte was requested while none was available |

## Verification
The hardest states to reach are the exact fill levels at the edges of the hysteresis band: 64 bits reached from below with `justify` still 1, and from above with it still 0. The symbol clock runs freely in use, so these levels cannot be held still. The bench therefore makes every symbol-clock edge itself, so it sets exactly how many symbols enter, and then drains bytes one at a time. That walks the fill through 80, 64, 56, 24, 64 and 104 bits. Discard-on-full is reached by writing 25 symbols with no reads, and the group-granular read limit by requesting a byte after only five symbols.

// File: rtl/efb_pkg.sv
// Shared helpers for the symbol-to-byte elastic buffer.
// Assumes pointer widths no larger than GRAY_MAX_W.
package efb_pkg;
    localparam int unsigned GRAY_MAX_W = 16;
    typedef logic [GRAY_MAX_W-1:0] gray_word_t;

    // Binary to reflected gray code.
    function automatic gray_word_t bin_to_gray(input gray_word_t b);
        return b ^ (b >> 1);
    endfunction

    // Reflected gray code back to binary.
    function automatic gray_word_t gray_to_bin(input gray_word_t g);
        gray_word_t b;
        b[GRAY_MAX_W-1] = g[GRAY_MAX_W-1];
        for (int i = GRAY_MAX_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/efb_sync.sv
// Two-stage synchronizer for a gray-coded pointer.
// Assumes the source changes at most one bit between its own clock edges.
module efb_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Capture the foreign pointer in two flop stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/efb_wr_ctl.sv
// Write-side control: walks the symbol slot address, counts completed groups
// as a gray pointer, and discards symbols when every group is still undrained.
// Assumes one symbol per clock edge and 2**PTR_W > 2*GROUPS.
module efb_wr_ctl
    import efb_pkg::*;
#(
    parameter int SYMS_PER_GRP = 8,
    parameter int GROUPS       = 3,
    parameter int PTR_W        = 4,
    parameter int IDX_W        = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PTR_W-1:0] rd_gray_s,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [PTR_W-1:0] wr_gray,
    output logic             overflow
);
    localparam int SUB_W  = $clog2(SYMS_PER_GRP);
    localparam int SLOT_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;

    logic [PTR_W-1:0]  grp_q, grp_nx, rd_bin, used;
    logic [SUB_W-1:0]  sub_q;
    logic [SLOT_W-1:0] slot_q;
    logic [PTR_W-1:0]  gray_q, gray_nx;
    logic              ovf_q;
    gray_word_t        wide_rd, wide_gray;

    // Decode the drained-group count and the space check.
    always_comb begin
        wide_rd   = gray_to_bin(gray_word_t'(rd_gray_s));
        rd_bin    = wide_rd[PTR_W-1:0];
        used      = grp_q - rd_bin;
        wr_en     = (used < PTR_W'(GROUPS));
        grp_nx    = grp_q + PTR_W'(1);
        wide_gray = bin_to_gray(gray_word_t'(grp_nx));
        gray_nx   = wide_gray[PTR_W-1:0];
        wr_idx    = IDX_W'(slot_q) * IDX_W'(SYMS_PER_GRP) + IDX_W'(sub_q);
    end

    // Advance the symbol position and record discards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q  <= '0;
            sub_q  <= '0;
            slot_q <= '0;
            gray_q <= '0;
            ovf_q  <= 1'b0;
        end else if (wr_en) begin
            if (sub_q == SUB_W'(SYMS_PER_GRP - 1)) begin
                sub_q  <= '0;
                grp_q  <= grp_nx;
                gray_q <= gray_nx;
                slot_q <= (slot_q == SLOT_W'(GROUPS - 1)) ? '0 : slot_q + SLOT_W'(1);
            end else begin
                sub_q <= sub_q + SUB_W'(1);
            end
        end else begin
            ovf_q <= 1'b1;
        end
    end

    assign wr_gray  = gray_q;
    assign overflow = ovf_q;

    p_wr_gray_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gray_q ^ $past(gray_q)) <= 1);
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> ovf_q);
endmodule

// File: rtl/efb_rd_ctl.sv
// Read-side control: hands out one byte per accepted request, counts drained
// groups as a gray pointer, and reports the number of readable bytes.
// Assumes the storage of a completed group is stable while it is read.
module efb_rd_ctl
    import efb_pkg::*;
#(
    parameter int BYTE_W        = 8,
    parameter int BYTES_PER_GRP = 5,
    parameter int GROUPS        = 3,
    parameter int PTR_W         = 4,
    parameter int BIDX_W        = 4,
    parameter int AV_W          = 7,
    parameter int MEM_BITS      = 120
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                next,
    input  logic [PTR_W-1:0]    wr_gray_s,
    input  logic [MEM_BITS-1:0] mem,
    output logic [BYTE_W-1:0]   rd_data,
    output logic [PTR_W-1:0]    rd_gray,
    output logic [AV_W-1:0]     avail,
    output logic                underflow
);
    localparam int NBYTES = GROUPS * BYTES_PER_GRP;
    localparam int SUB_W  = $clog2(BYTES_PER_GRP);
    localparam int SLOT_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;

    logic [BYTE_W-1:0] bytes [NBYTES];
    logic [PTR_W-1:0]  grp_q, grp_nx, wr_bin, diff;
    logic [SUB_W-1:0]  sub_q;
    logic [SLOT_W-1:0] slot_q;
    logic [PTR_W-1:0]  gray_q, gray_nx;
    logic [BIDX_W-1:0] bidx;
    logic [BYTE_W-1:0] data_q;
    logic              udf_q, take;
    gray_word_t        wide_wr, wide_gray;

    // Slice the flat storage into byte lanes.
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign bytes[g] = mem[g*BYTE_W +: BYTE_W];
    end

    // Readable bytes and the position of the next one.
    always_comb begin
        wide_wr   = gray_to_bin(gray_word_t'(wr_gray_s));
        wr_bin    = wide_wr[PTR_W-1:0];
        diff      = wr_bin - grp_q;
        avail     = AV_W'(diff) * AV_W'(BYTES_PER_GRP) - AV_W'(sub_q);
        take      = next && (avail != '0);
        bidx      = BIDX_W'(slot_q) * BIDX_W'(BYTES_PER_GRP) + BIDX_W'(sub_q);
        grp_nx    = grp_q + PTR_W'(1);
        wide_gray = bin_to_gray(gray_word_t'(grp_nx));
        gray_nx   = wide_gray[PTR_W-1:0];
    end

    // Serve requests, advance the byte position, record empty requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q  <= '0;
            sub_q  <= '0;
            slot_q <= '0;
            gray_q <= '0;
            data_q <= '0;
            udf_q  <= 1'b0;
        end else if (take) begin
            data_q <= bytes[bidx];
            if (sub_q == SUB_W'(BYTES_PER_GRP - 1)) begin
                sub_q  <= '0;
                grp_q  <= grp_nx;
                gray_q <= gray_nx;
                slot_q <= (slot_q == SLOT_W'(GROUPS - 1)) ? '0 : slot_q + SLOT_W'(1);
            end else begin
                sub_q <= sub_q + SUB_W'(1);
            end
        end else if (next) begin
            udf_q <= 1'b1;
        end
    end

    assign rd_data   = data_q;
    assign rd_gray   = gray_q;
    assign underflow = udf_q;

    p_rd_gray_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gray_q ^ $past(gray_q)) <= 1);
    p_udf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        udf_q |=> udf_q);
    p_empty_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (next && avail == '0) |=> $stable(data_q));
    p_avail_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        avail <= AV_W'(NBYTES));
endmodule

// File: rtl/efb_just.sv
// Justification decision with hysteresis on the byte-domain fill level.
// Assumes fill is expressed in bits and HYST is below HI.
module efb_just #(
    parameter int FILL_W = 10,
    parameter int HI     = 64,
    parameter int HYST   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FILL_W-1:0] fill,
    output logic              justify
);
    localparam int LO = HI - HYST;

    logic just_q;

    // Drop to data-carrying above HI, back to dummy at or below LO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            just_q <= 1'b1;
        end else if (fill > FILL_W'(HI)) begin
            just_q <= 1'b0;
        end else if (fill <= FILL_W'(LO)) begin
            just_q <= 1'b1;
        end
    end

    assign justify = just_q;

    p_fall_above_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(just_q) |-> ($past(fill) > FILL_W'(HI)));
    p_rise_at_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(just_q) |-> ($past(fill) <= FILL_W'(LO)));
    p_hold_in_band_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill > FILL_W'(LO) && fill <= FILL_W'(HI)) |=> $stable(just_q));
endmodule

// File: rtl/sym2byte_elastic.sv
// Symbol-to-byte elastic buffer: symbols in on one clock, bytes out on request
// on another, with a hysteresis justification decision from the fill level.
// Assumes both resets are applied together with their clocks running.
module sym2byte_elastic
    import efb_pkg::*;
#(
    parameter int SYM_W     = 5,
    parameter int BYTE_W    = 8,
    parameter int GROUPS    = 3,
    parameter int PTR_W     = 4,
    parameter int JUST_HI   = 64,
    parameter int JUST_HYST = 8
) (
    input  logic              sym_clk,
    input  logic              sym_rst_n,
    input  logic [SYM_W-1:0]  sym_in,
    input  logic              byte_clk,
    input  logic              byte_rst_n,
    input  logic              byte_next,
    output logic [BYTE_W-1:0] byte_out,
    output logic              justify,
    output logic              ovf_flag,
    output logic              udf_flag
);
    localparam int SYMS_PER_GRP  = BYTE_W;
    localparam int BYTES_PER_GRP = SYM_W;
    localparam int NSYMS         = GROUPS * SYMS_PER_GRP;
    localparam int NBYTES        = GROUPS * BYTES_PER_GRP;
    localparam int MEM_BITS      = NSYMS * SYM_W;
    localparam int IDX_W         = $clog2(NSYMS);
    localparam int BIDX_W        = $clog2(NBYTES);
    localparam int AV_W          = $clog2((1 << PTR_W) * BYTES_PER_GRP + 1);
    localparam int FILL_W        = AV_W + $clog2(BYTE_W);

    logic [MEM_BITS-1:0] mem_q;
    logic                wr_en;
    logic [IDX_W-1:0]    wr_idx;
    logic [PTR_W-1:0]    wr_gray, wr_gray_s, rd_gray, rd_gray_s;
    logic [AV_W-1:0]     avail;
    logic [FILL_W-1:0]   fill;

    // Symbol storage: one lane per slot, written in the symbol domain.
    for (genvar g = 0; g < NSYMS; g++) begin : g_slot
        always_ff @(posedge sym_clk) begin
            if (sym_rst_n && wr_en && wr_idx == IDX_W'(g)) begin
                mem_q[g*SYM_W +: SYM_W] <= sym_in;
            end
        end
    end

    efb_wr_ctl #(
        .SYMS_PER_GRP(SYMS_PER_GRP),
        .GROUPS      (GROUPS),
        .PTR_W       (PTR_W),
        .IDX_W       (IDX_W)
    ) u_wr (
        .clk      (sym_clk),
        .rst_n    (sym_rst_n),
        .rd_gray_s(rd_gray_s),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_gray  (wr_gray),
        .overflow (ovf_flag)
    );

    efb_sync #(.W(PTR_W)) u_sync_w2r (
        .clk  (byte_clk),
        .rst_n(byte_rst_n),
        .d    (wr_gray),
        .q    (wr_gray_s)
    );

    efb_sync #(.W(PTR_W)) u_sync_r2w (
        .clk  (sym_clk),
        .rst_n(sym_rst_n),
        .d    (rd_gray),
        .q    (rd_gray_s)
    );

    efb_rd_ctl #(
        .BYTE_W       (BYTE_W),
        .BYTES_PER_GRP(BYTES_PER_GRP),
        .GROUPS       (GROUPS),
        .PTR_W        (PTR_W),
        .BIDX_W       (BIDX_W),
        .AV_W         (AV_W),
        .MEM_BITS     (MEM_BITS)
    ) u_rd (
        .clk      (byte_clk),
        .rst_n    (byte_rst_n),
        .next     (byte_next),
        .wr_gray_s(wr_gray_s),
        .mem      (mem_q),
        .rd_data  (byte_out),
        .rd_gray  (rd_gray),
        .avail    (avail),
        .underflow(udf_flag)
    );

    assign fill = FILL_W'(avail) * FILL_W'(BYTE_W);

    efb_just #(
        .FILL_W(FILL_W),
        .HI    (JUST_HI),
        .HYST  (JUST_HYST)
    ) u_just (
        .clk    (byte_clk),
        .rst_n  (byte_rst_n),
        .fill   (fill),
        .justify(justify)
    );
endmodule

// File: tb/sim_sym2byte_elastic.sv
module sim_sym2byte_elastic;
    logic       sym_clk = 1'b0, byte_clk = 1'b0;
    logic       sym_rst_n = 1'b0, byte_rst_n = 1'b0;
    logic       byte_next = 1'b0;
    logic [4:0] sym_in = '0;
    logic [7:0] byte_out;
    logic       justify, ovf_flag, udf_flag;

    sym2byte_elastic u0 (
        .sym_clk(sym_clk), .sym_rst_n(sym_rst_n), .sym_in(sym_in),
        .byte_clk(byte_clk), .byte_rst_n(byte_rst_n), .byte_next(byte_next),
        .byte_out(byte_out), .justify(justify),
        .ovf_flag(ovf_flag), .udf_flag(udf_flag)
    );

    always #10 byte_clk = ~byte_clk;

    int   n_chk = 0, n_fail = 0;
    bit   eq[$];
    int   ws_acc, rb;
    bit   exp_ovf, exp_udf, exp_j;
    logic [7:0] last_byte;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int avail_bytes();
        return (ws_acc / 8) * 5 - rb;
    endfunction

    // Hysteresis model on fill in bits.
    task automatic upd_j();
        int f;
        f = avail_bytes() * 8;
        if (f > 64) exp_j = 1'b0;
        else if (f <= 56) exp_j = 1'b1;
    endtask

    task automatic pulse(input logic [4:0] v);
        sym_in = v;
        #20 sym_clk = 1'b1;
        #20 sym_clk = 1'b0;
    endtask

    task automatic put_sym(input logic [4:0] v);
        if ((ws_acc / 8) - (rb / 5) < 3) begin
            for (int i = 0; i < 5; i++) eq.push_back(v[i]);
            ws_acc++;
            if (ws_acc % 8 == 0) upd_j();
        end else begin
            exp_ovf = 1'b1;
        end
        pulse(v);
    endtask

    task automatic settle();
        repeat (4) @(negedge byte_clk);
    endtask

    task automatic get_byte(input string req);
        logic [7:0] e;
        int av;
        av = avail_bytes();
        @(negedge byte_clk) byte_next = 1'b1;
        @(negedge byte_clk) byte_next = 1'b0;
        if (av > 0) begin
            for (int i = 0; i < 8; i++) e[i] = eq.pop_front();
            rb++;
            last_byte = e;
            upd_j();
        end else begin
            exp_udf = 1'b1;
        end
        check(byte_out === last_byte, req, "byte_out", int'(byte_out), int'(last_byte));
    endtask

    task automatic check_flags(input string req);
        check(justify === exp_j, req, "justify", int'(justify), int'(exp_j));
        check(ovf_flag === exp_ovf, req, "ovf_flag", int'(ovf_flag), int'(exp_ovf));
        check(udf_flag === exp_udf, req, "udf_flag", int'(udf_flag), int'(exp_udf));
    endtask

    task automatic do_reset();
        sym_rst_n = 1'b0;
        byte_rst_n = 1'b0;
        repeat (3) pulse(5'd0);
        repeat (3) @(negedge byte_clk);
        sym_rst_n = 1'b1;
        byte_rst_n = 1'b1;
        eq.delete();
        ws_acc = 0; rb = 0;
        exp_ovf = 0; exp_udf = 0; exp_j = 1; last_byte = '0;
        settle();
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state.
        do_reset();
        check(byte_out === 8'd0, "R1", "byte_out", int'(byte_out), 0);
        check_flags("R1");

        // R5: a partial group is not readable; the request underflows (R4).
        for (int i = 0; i < 5; i++) put_sym(5'(i * 3 + 1));
        settle();
        get_byte("R5");
        check(udf_flag === 1'b1, "R4", "udf_flag", int'(udf_flag), 1);
        for (int i = 5; i < 8; i++) put_sym(5'(i * 3 + 1));
        settle();
        for (int i = 0; i < 5; i++) get_byte("R5");
        check(udf_flag === 1'b1, "R4", "udf sticky", int'(udf_flag), 1);

        // R2 and R8: streaming over many wraps with varied patterns.
        do_reset();
        check_flags("R4");
        for (int r = 0; r < 40; r++) begin
            int k;
            k = 1 + (r % 2);
            for (int i = 0; i < 8 * k; i++) put_sym(5'((r * 13 + i * 7 + r * i) & 31));
            settle();
            check(justify === exp_j, "R6", "justify after write", int'(justify), int'(exp_j));
            for (int i = 0; i < 5 * k; i++) get_byte((r < 4) ? "R2" : "R8");
            settle();
            check(justify === exp_j, "R7", "justify after drain", int'(justify), int'(exp_j));
        end
        check_flags("R8");

        // R6/R7: walk the fill through the hysteresis band.
        do_reset();
        for (int i = 0; i < 16; i++) put_sym(5'((i * 11 + 5) & 31));
        settle();
        check(justify === 1'b0, "R6", "justify at 80", int'(justify), 0);
        repeat (2) get_byte("R2");
        settle();
        check(justify === 1'b0, "R7", "justify hold at 64", int'(justify), 0);
        get_byte("R2");
        settle();
        check(justify === 1'b1, "R7", "justify at 56", int'(justify), 1);
        repeat (4) get_byte("R2");
        settle();
        check(justify === 1'b1, "R7", "justify at 24", int'(justify), 1);
        for (int i = 0; i < 8; i++) put_sym(5'((i * 5 + 2) & 31));
        settle();
        check(justify === 1'b1, "R7", "justify hold 64 from below", int'(justify), 1);
        for (int i = 0; i < 8; i++) put_sym(5'((i * 9 + 17) & 31));
        settle();
        check(justify === 1'b0, "R6", "justify at 104", int'(justify), 0);
        repeat (13) get_byte("R8");
        settle();
        check(justify === 1'b1, "R7", "justify at 0", int'(justify), 1);
        check(udf_flag === 1'b0, "R4", "udf before empty read", int'(udf_flag), 0);
        get_byte("R4");
        check(udf_flag === 1'b1, "R4", "udf after empty read", int'(udf_flag), 1);

        // R3: discard on full, sticky overflow.
        do_reset();
        for (int i = 0; i < 24; i++) put_sym(5'((i * 19 + 4) & 31));
        settle();
        check(ovf_flag === 1'b0, "R3", "ovf when just full", int'(ovf_flag), 0);
        put_sym(5'd31);
        settle();
        check(ovf_flag === 1'b1, "R3", "ovf after discard", int'(ovf_flag), 1);
        for (int i = 0; i < 15; i++) get_byte("R3");
        get_byte("R4");
        settle();
        check_flags("R3");

        // R1: resets clear both sticky flags.
        do_reset();
        check_flags("R1");

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule